// File: doc/BRIEF.md
# Canonical Function Arithmetic-Logic Unit

This block is a purely combinational datapath unit that serves as a reference model for a fixed canonical set of word operations. It has two data words, a carry input and a five-bit function code. It produces a data word, a carry flag, an overflow flag and a single compare bit. Exactly one operation is active at a time, and the function code selects it. All data is two's complement.

The set holds 27 operations in three families. There are five arithmetic operations: add, subtract, reverse subtract, increment and decrement. There are all sixteen bitwise Boolean functions of two variables. There are six signed comparisons: equal, not equal, greater, greater-or-equal, less and less-or-equal. Each operation drives only the outputs its family owns and holds every other output at zero. This lets a neighbour tell from the outputs alone which family was active. The word width is a parameter. The block has no storage, so its outputs follow its inputs within the same cycle.

Top module: `canon_alu`

## Requirements
- R1: Code 0 (add) gives {carry_out, result} = op_a + op_b + carry_in, computed as an unsigned sum WIDTH+1 bits wide.
- R2: Code 1 (subtract) computes op_a + ~op_b + carry_in, and code 2 (reverse subtract) computes op_b + ~op_a + carry_in. The carry out of that sum appears on carry_out, so carry_in=1 yields a true difference.
- R3: Code 3 (increment) gives op_a + 1 and code 4 (decrement) gives op_a + all-ones. Both ignore carry_in and report carry_out and overflow.
- R4: For codes 0 to 4, overflow is 1 exactly when the signed value of the operation cannot be represented in WIDTH bits.
- R5: Codes 16 to 31 are bitwise functions. For each bit i, result[i] = func_sel[2*op_a[i] + op_b[i]], so the low four code bits form the truth table (for example 22 is XOR and 23 is NAND).
- R6: During a bitwise function, carry_in has no effect, and carry_out, overflow and cmp_out are all 0.
- R7: Codes 8 to 13 are signed comparisons of op_a against op_b, in the order EQ, NEQ, GT, GEQ, LT, LEQ. The answer appears on cmp_out, while result, carry_out and overflow are 0.
- R8: Codes 5, 6, 7, 14 and 15 are unused and drive every output to 0.
- R9: During an arithmetic operation (codes 0 to 4), cmp_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (left side of the operation) |
| op_b | input | WIDTH | Second operand (right side of the operation) |
| carry_in | input | 1 | Carry into add, subtract and reverse subtract |
| func_sel | input | 5 | Function code selecting one operation |
| result | output | WIDTH | Word result of arithmetic and bitwise functions |
| carry_out | output | 1 | Carry out of the arithmetic sum |
| overflow | output | 1 | Signed overflow of the arithmetic operation |
| cmp_out | output | 1 | Outcome of the selected comparison |

## Verification
The bench targets several sign boundaries:
- Adding 0x7F and 0x01, incrementing 0x7F and decrementing 0x80 all cross the sign boundary. A design that takes overflow from the carry would miss these.
- Adding 0xFF and 0x01 carries out with no overflow. A design that confuses the two flags would get this wrong.
- Comparing 0x01 with 0xFF and 0x80 with 0x7F shows at once whether the comparisons are unsigned instead of signed.

Other cases exercise the rest:
- Bitwise codes are driven with carry_in high, and increment is driven with carry_in high, to catch a carry leaking into operations that must ignore it.
- Unused codes are driven with all-ones operands, so a decoder that falls through to a neighbouring function shows a non-zero word.
- A long random sweep over all 32 codes catches swapped operands in reverse subtract and a truth-table index taken in the wrong bit order.

// File: rtl/canon_alu_pkg.sv
`timescale 1ns/1ps
// Package: function codes and family decoding shared by the ALU and its checker.
// Assumes a five-bit function code; bit 4 set marks a bitwise function.
package canon_alu_pkg;

    localparam int SEL_W = 5;

    typedef enum logic [SEL_W-1:0] {
        FN_ADD  = 5'd0,
        FN_SUB  = 5'd1,
        FN_RSUB = 5'd2,
        FN_INC  = 5'd3,
        FN_DEC  = 5'd4,
        FN_EQ   = 5'd8,
        FN_NEQ  = 5'd9,
        FN_GT   = 5'd10,
        FN_GEQ  = 5'd11,
        FN_LT   = 5'd12,
        FN_LEQ  = 5'd13
    } fn_code_e;

    typedef enum logic [1:0] {
        FAM_NONE  = 2'd0,
        FAM_ARITH = 2'd1,
        FAM_BOOL  = 2'd2,
        FAM_CMP   = 2'd3
    } fam_e;

    // Map a function code onto its operation family.
    function automatic fam_e family_of(input logic [SEL_W-1:0] code);
        if (code[4])
            return FAM_BOOL;
        else if (code <= 5'd4)
            return FAM_ARITH;
        else if (code >= 5'd8 && code <= 5'd13)
            return FAM_CMP;
        else
            return FAM_NONE;
    endfunction

endpackage

// File: rtl/canon_alu_arith.sv
`timescale 1ns/1ps
// Arithmetic family: one shared adder whose operands are steered per code.
// Assumes code is 0..4; any other value falls back to the add operands
// (the top masks the outputs in that case).
module canon_alu_arith #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic [2:0]       kind,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO     = '0;

    logic [WIDTH-1:0] x, y;
    logic             c0;
    logic [WIDTH:0]   full;

    // Steer the adder inputs for the selected arithmetic operation.
    always_comb begin
        unique case (kind)
            3'd1:    begin x = a; y = ~b;       c0 = cin;  end
            3'd2:    begin x = b; y = ~a;       c0 = cin;  end
            3'd3:    begin x = a; y = ZERO;     c0 = 1'b1; end
            3'd4:    begin x = a; y = ALL_ONES; c0 = 1'b0; end
            default: begin x = a; y = b;        c0 = cin;  end
        endcase
    end

    // Single ripple of the shared adder plus signed overflow from the sign bits.
    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c0};
        sum  = full[WIDTH-1:0];
        cout = full[WIDTH];
        ovf  = (x[WIDTH-1] == y[WIDTH-1]) && (full[WIDTH-1] != x[WIDTH-1]);
    end

endmodule

// File: rtl/canon_alu_bool.sv
`timescale 1ns/1ps
// Bitwise family: each bit picks one entry of a four-entry truth table,
// indexed by {a bit, b bit}. Covers all sixteen two-input functions.
module canon_alu_bool #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       table_bits,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Minterm select for bit i.
        always_comb y[i] = table_bits[{a[i], b[i]}];
    end

endmodule

// File: rtl/canon_alu_cmp.sv
`timescale 1ns/1ps
// Compare family: signed relations of a against b, selected by the low
// three code bits (0 EQ, 1 NEQ, 2 GT, 3 GEQ, 4 LT, 5 LEQ).
module canon_alu_cmp #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       rel,
    output logic             flag
);
    logic eq, lt;

    // Equality and signed less-than are the two base relations.
    always_comb begin
        eq = (a == b);
        lt = ($signed(a) < $signed(b));
    end

    // Derive the requested relation from the base pair.
    always_comb begin
        unique case (rel)
            3'd0:    flag = eq;
            3'd1:    flag = !eq;
            3'd2:    flag = !lt && !eq;
            3'd3:    flag = !lt;
            3'd4:    flag = lt;
            3'd5:    flag = lt || eq;
            default: flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/canon_alu.sv
`timescale 1ns/1ps
// Top: canonical-function ALU. Decodes the function family, runs the three
// family units in parallel and lets only the active family reach the
// outputs; every other output is held at zero. Purely combinational.
module canon_alu
    import canon_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [4:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow,
    output logic             cmp_out
);
    fam_e             fam;
    logic [WIDTH-1:0] ar_sum, bl_word;
    logic             ar_cout, ar_ovf, cmp_flag;

    // Family decode of the function code.
    always_comb fam = family_of(func_sel);

    canon_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .a    (op_a),
        .b    (op_b),
        .cin  (carry_in),
        .kind (func_sel[2:0]),
        .sum  (ar_sum),
        .cout (ar_cout),
        .ovf  (ar_ovf)
    );

    canon_alu_bool #(.WIDTH(WIDTH)) u_bool (
        .a          (op_a),
        .b          (op_b),
        .table_bits (func_sel[3:0]),
        .y          (bl_word)
    );

    canon_alu_cmp #(.WIDTH(WIDTH)) u_cmp (
        .a    (op_a),
        .b    (op_b),
        .rel  (func_sel[2:0]),
        .flag (cmp_flag)
    );

    // Output steering: only the active family drives, the rest stay at zero.
    always_comb begin
        result    = '0;
        carry_out = 1'b0;
        overflow  = 1'b0;
        cmp_out   = 1'b0;
        unique case (fam)
            FAM_ARITH: begin
                result    = ar_sum;
                carry_out = ar_cout;
                overflow  = ar_ovf;
            end
            FAM_BOOL:  result  = bl_word;
            FAM_CMP:   cmp_out = cmp_flag;
            default:   ;
        endcase
    end

endmodule

// File: rtl/canon_alu_chk.sv
`timescale 1ns/1ps
// Checker: port-level rules of the ALU as immediate assertions, evaluated
// whenever the combinational outputs settle. Bound to every canon_alu.
module canon_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [4:0]       func_sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             overflow,
    input logic             cmp_out
);
    // Port rules per code family.
    always_comb begin
        if (func_sel == 5'd0) begin
            a_r1_add_sum: assert ({carry_out, result} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
            a_r4_add_ovf_sign: assert (!overflow ||
                ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (result[WIDTH-1] != op_a[WIDTH-1])));
        end
        if (func_sel[4]) begin
            a_r6_bool_flags_quiet: assert (!carry_out && !overflow && !cmp_out);
        end
        if (func_sel >= 5'd8 && func_sel <= 5'd13) begin
            a_r7_cmp_word_zero: assert (result == '0 && !carry_out && !overflow);
        end
        if (func_sel inside {5'd5, 5'd6, 5'd7, 5'd14, 5'd15}) begin
            a_r8_unused_silent: assert (result == '0 && !carry_out && !overflow && !cmp_out);
        end
        if (func_sel <= 5'd4) begin
            a_r9_arith_cmp_low: assert (!cmp_out);
        end
    end

endmodule

bind canon_alu canon_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .func_sel  (func_sel),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .cmp_out   (cmp_out)
);

// File: tb/tb_canon_alu.sv
`timescale 1ns/1ps
// Bench: table of hand-computed vectors, then directed flag checks, then a
// random sweep against a behavioural model over every function code.
module tb_canon_alu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         carry_in = 1'b0;
    logic [4:0]   func_sel = '0;
    logic [W-1:0] result;
    logic         carry_out, overflow, cmp_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    canon_alu #(.WIDTH(W)) dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .func_sel(func_sel),
        .result(result), .carry_out(carry_out), .overflow(overflow), .cmp_out(cmp_out)
    );

    typedef struct packed {
        logic [4:0]   sel;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic [W-1:0] r;
        logic         co;
        logic         ov;
        logic         cm;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0},
        '{5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{5'd0,  8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0},
        '{5'd1,  8'h05, 8'h07, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0},
        '{5'd1,  8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 1'b1, 1'b0},
        '{5'd2,  8'h03, 8'h0A, 1'b1, 8'h07, 1'b1, 1'b0, 1'b0},
        '{5'd3,  8'h7F, 8'h00, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0},
        '{5'd3,  8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{5'd3,  8'h10, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0},
        '{5'd4,  8'h80, 8'h00, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b0},
        '{5'd4,  8'h00, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{5'd22, 8'hCC, 8'hAA, 1'b0, 8'h66, 1'b0, 1'b0, 1'b0},
        '{5'd23, 8'hCC, 8'hAA, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0},
        '{5'd31, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{5'd10, 8'h01, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd12, 8'h80, 8'h7F, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd13, 8'h05, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd11, 8'h80, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd8,  8'h5A, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
        '{5'd9,  8'h5A, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{5'd5,  8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}
    };

    // Requirement tag that covers a given function code.
    function automatic string req_of(input logic [4:0] s);
        if (s[4])                return "R5";
        if (s == 5'd0)           return "R1";
        if (s <= 5'd2)           return "R2";
        if (s <= 5'd4)           return "R3";
        if (s >= 5'd8 && s <= 5'd13) return "R7";
        return "R8";
    endfunction

    // Behavioural model written from the requirements.
    function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic cin, input logic [4:0] s);
        int sa, sb, exact, u;
        logic [W-1:0] r;
        logic co, ov, cm;
        sa = $signed(a); sb = $signed(b);
        r = '0; co = 0; ov = 0; cm = 0; u = 0; exact = 0;
        if (s <= 5'd4) begin
            case (s)
                5'd0: begin u = a + b + cin;                 exact = sa + sb + cin;     end
                5'd1: begin u = a + ((1 << W) - 1 - b) + cin; exact = sa - sb - 1 + cin; end
                5'd2: begin u = b + ((1 << W) - 1 - a) + cin; exact = sb - sa - 1 + cin; end
                5'd3: begin u = a + 1;                       exact = sa + 1;           end
                default: begin u = a + (1 << W) - 1;         exact = sa - 1;           end
            endcase
            r  = u[W-1:0];
            co = u[W];
            ov = (exact > (1 << (W-1)) - 1) || (exact < -(1 << (W-1)));
        end else if (s[4]) begin
            for (int i = 0; i < W; i++) r[i] = s[2*a[i] + b[i]];
        end else begin
            case (s)
                5'd8:  cm = (sa == sb);
                5'd9:  cm = (sa != sb);
                5'd10: cm = (sa > sb);
                5'd11: cm = (sa >= sb);
                5'd12: cm = (sa < sb);
                5'd13: cm = (sa <= sb);
                default: cm = 0;
            endcase
        end
        return {r, co, ov, cm};
    endfunction

    task automatic check(input string req, input logic [W+2:0] got, input logic [W+2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: sel=%0d a=%h b=%h cin=%0b got {r,co,ov,cm}=%h expected %h",
                     req, func_sel, op_a, op_b, carry_in, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] s, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic cin);
        @(posedge clk);
        func_sel = s; op_a = a; op_b = b; carry_in = cin;
        @(negedge clk);
    endtask

    function automatic logic [W+2:0] outs();
        return {result, carry_out, overflow, cmp_out};
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle inputs (add of zeros) give all-zero outputs.
        check("R1 initial", outs(), '0);

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].sel, VECS[k].a, VECS[k].b, VECS[k].cin);
            check(req_of(VECS[k].sel), outs(), {VECS[k].r, VECS[k].co, VECS[k].ov, VECS[k].cm});
        end

        // R4: overflow on add of two negatives that wraps positive.
        apply(5'd0, 8'h80, 8'h80, 1'b0);
        check("R4", {result, carry_out, overflow, cmp_out}, {8'h00, 1'b1, 1'b1, 1'b0});
        // R6: bitwise function with carry_in high and result bits all set.
        apply(5'd30, 8'hF0, 8'h0F, 1'b1);
        check("R6", outs(), {8'hFF, 1'b0, 1'b0, 1'b0});
        apply(5'd30, 8'hF0, 8'h0F, 1'b0);
        check("R6", outs(), {8'hFF, 1'b0, 1'b0, 1'b0});
        // R9: subtract of equal operands leaves the compare bit low.
        apply(5'd1, 8'h33, 8'h33, 1'b1);
        check("R9", outs(), {8'h00, 1'b1, 1'b0, 1'b0});
        // R8: every unused code with all-ones operands.
        foreach (VECS[0].sel[i]) begin end
        for (int c = 5; c < 16; c++) begin
            if (c == 5 || c == 6 || c == 7 || c == 14 || c == 15) begin
                apply(c[4:0], 8'hFF, 8'hFF, 1'b1);
                check("R8", outs(), '0);
            end
        end

        // Random sweep across all codes against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] s;
            logic [W-1:0] a, b;
            logic c;
            s = 5'($urandom_range(0, 31));
            a = W'($urandom);
            b = (n % 7 == 0) ? a : W'($urandom);
            c = 1'($urandom);
            apply(s, a, b, c);
            check(req_of(s), outs(), model(a, b, c, s));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule